// File: doc/BRIEF.md
# Thermal Clock Throttle Governor

The governor keeps a clock multiplier inside a temperature-dependent limit. A temperature sensor delivers a raw 16-bit two's-complement code together with a sample strobe. The block converts each code to a fixed-point temperature with 1/32 °C resolution and rounds it to whole degrees. It then compares the result with a target temperature and a hysteresis band, and it adjusts the multiplier and an adjustable ceiling. The clock frequency in MHz is twice the multiplier. The multiplier starts at 100, which is 200 MHz. The ceiling can never exceed the absolute limit of 125, which is 250 MHz.

When the part runs hot, the multiplier is cut by one step. The ceiling follows it down, and only one cut is allowed per one-second window. When the part cools, the ceiling is raised again. If the temperature is below the band, the ceiling is restored to the absolute limit at once. If the temperature is inside the lower half of the band, the ceiling is raised by one step, but only while the multiplier sits at the ceiling. An outside controller may request a new multiplier at any time. The block clamps that request between the floor of 1 and the present ceiling.

Top module: `thermal_throttle_gov`

## Requirements
- R1: The converted temperature is the 16-bit code shifted right arithmetically by two bits. `temp_q` shows it as a 14-bit signed value in units of 1/32 °C. `temp_deg` shows it rounded to the nearest whole degree, with halves rounded away from zero. Both outputs update on the clock edge that takes a sample and hold their value until the next sample.
- R2: The codes 16'h0000 and 16'hFFFF are invalid. For an invalid code, `temp_q` and `temp_deg` become 0. The multiplier, the ceiling and the cut window are left unchanged.
- R3: A valid sample whose rounded temperature exceeds target plus hysteresis triggers a cut if the cut window is open. The multiplier becomes the larger of (multiplier − 1) and 1, the ceiling becomes that new multiplier, and the window closes.
- R4: The cut window reopens on `sec_tick`. A tick in the same cycle as a hot sample opens the window before the decision is made. While the window is closed, a hot sample changes nothing.
- R5: A valid sample whose rounded temperature is below target minus hysteresis restores the ceiling to 125, provided the ceiling is below 125. The multiplier is not changed.
- R6: A valid sample that meets all of the following raises the ceiling by one:
  - the rounded temperature is at least target minus hysteresis;
  - the rounded temperature is below target;
  - the ceiling is below 125;
  - the multiplier equals the ceiling.
- R7: A valid sample whose rounded temperature lies from target up to target plus hysteresis, both inclusive, changes neither the multiplier nor the ceiling.
- R8: A request (`set_valid`) sets the multiplier to `set_mult` clamped into the range from 1 up to the current ceiling. A request made in the same cycle as `samp_valid` is ignored.
- R9: `mult_chg` is high for exactly one cycle: the first cycle in which a changed multiplier is visible. It stays low when the multiplier keeps its value.
- R10: After reset:
  - `mult` = 100;
  - `ceil_mult` = 125;
  - `temp_q` = 0, `temp_deg` = 0;
  - `mult_chg` = 0;
  - the cut window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse each second; reopens the cut window |
| samp_valid | input | 1 | Sample strobe for `samp_code` |
| samp_code | input | 16 | Raw signed temperature code |
| target_deg | input | 10 | Target temperature, signed whole °C |
| hyst_deg | input | 8 | Hysteresis, unsigned whole °C |
| set_valid | input | 1 | Multiplier request strobe |
| set_mult | input | 8 | Requested multiplier |
| mult | output | 8 | Current multiplier (half the frequency in MHz) |
| ceil_mult | output | 8 | Adjustable ceiling |
| mult_chg | output | 1 | Pulse: multiplier changed |
| temp_q | output | 14 | Temperature, signed, 1/32 °C units |
| temp_deg | output | 10 | Temperature, signed, rounded whole °C |

## Verification
Both the multiplier and the ceiling are visible at the ports, so a wrong thermal decision shows on `mult` or `ceil_mult` one cycle after the sample that caused it. A conversion error shows on `temp_q` or `temp_deg` in that same cycle. A stuck or leaking cut window is harder to see: it shows only when a second hot sample arrives before the next tick, as a second cut that should not happen, or as a missing cut after a tick. The bench therefore places hot samples densely both between ticks and on the tick cycle itself. A wrong rounding of the half-degree points can move a temperature into the wrong band, so codes at and beside those points are swept.

// File: rtl/thr_pkg.sv
package thr_pkg;
  // sensor code format
  localparam int CODE_W = 16;
  localparam int SHIFT  = 2;
  localparam int FRAC   = 5;
  localparam int Q_W    = CODE_W - SHIFT;
  localparam int DEG_W  = Q_W - FRAC + 1;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_INVALID,
    ACT_CUT,
    ACT_HOT_HELD,
    ACT_RESTORE,
    ACT_STEP,
    ACT_SET
  } act_e;

  function automatic logic signed [Q_W-1:0] code_to_q(input logic [CODE_W-1:0] code);
    logic signed [CODE_W-1:0] s;
    s = $signed(code) >>> SHIFT;
    return s[Q_W-1:0];
  endfunction

  function automatic logic signed [DEG_W-1:0] q_to_deg(input logic signed [Q_W-1:0] q);
    logic [Q_W:0] mag;
    logic [Q_W:0] r;
    mag = q[Q_W-1] ? ($unsigned(-{q[Q_W-1], q})) : {1'b0, $unsigned(q)};
    r = (mag + (Q_W+1)'(1 << (FRAC-1))) >> FRAC;
    return q[Q_W-1] ? -$signed(r[DEG_W-1:0]) : $signed(r[DEG_W-1:0]);
  endfunction
endpackage

// File: rtl/thr_conv.sv
module thr_conv
  import thr_pkg::*;
(
  input  logic [CODE_W-1:0]       code,
  output logic                    invalid,
  output logic signed [Q_W-1:0]   q,
  output logic signed [DEG_W-1:0] deg
);
  always_comb begin
    invalid = (code == '0) || (code == '1);
    q       = code_to_q(code);
    deg     = q_to_deg(q);
  end
endmodule

// File: rtl/thr_decide.sv
module thr_decide
  import thr_pkg::*;
#(
  parameter int MULT_W   = 8,
  parameter int HYST_W   = 8,
  parameter int ABS_MULT = 125
) (
  input  logic                    samp_valid,
  input  logic                    invalid,
  input  logic signed [DEG_W-1:0] deg,
  input  logic signed [DEG_W-1:0] target,
  input  logic [HYST_W-1:0]       hyst,
  input  logic                    win_open,
  input  logic                    set_valid,
  input  logic [MULT_W-1:0]       mult,
  input  logic [MULT_W-1:0]       ceil_m,
  output act_e                    act
);
  localparam int CMP_W = ((DEG_W > HYST_W) ? DEG_W : HYST_W + 1) + 2;

  logic signed [CMP_W-1:0] d_x, hi, lo, tg;

  always_comb begin
    d_x = CMP_W'(deg);
    tg  = CMP_W'(target);
    hi  = tg + $signed({{(CMP_W-HYST_W){1'b0}}, hyst});
    lo  = tg - $signed({{(CMP_W-HYST_W){1'b0}}, hyst});
    act = ACT_NONE;
    if (samp_valid) begin
      if (invalid) begin
        act = ACT_INVALID;
      end else if (d_x > hi) begin
        act = win_open ? ACT_CUT : ACT_HOT_HELD;
      end else if ((ceil_m < MULT_W'(ABS_MULT)) && (d_x < tg)) begin
        if (d_x < lo) begin
          act = ACT_RESTORE;
        end else if (mult == ceil_m) begin
          act = ACT_STEP;
        end
      end
    end else if (set_valid) begin
      act = ACT_SET;
    end
  end
endmodule

// File: rtl/thr_state.sv
module thr_state
  import thr_pkg::*;
#(
  parameter int MULT_W   = 8,
  parameter int DEF_MULT = 100,
  parameter int ABS_MULT = 125,
  parameter int MIN_MULT = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sec_tick,
  input  act_e                    act,
  input  logic [MULT_W-1:0]       set_mult,
  input  logic                    samp_valid,
  input  logic                    invalid,
  input  logic signed [Q_W-1:0]   q_in,
  input  logic signed [DEG_W-1:0] deg_in,
  output logic                    win_now,
  output logic [MULT_W-1:0]       mult,
  output logic [MULT_W-1:0]       ceil_m,
  output logic                    mult_chg,
  output logic signed [Q_W-1:0]   temp_q,
  output logic signed [DEG_W-1:0] temp_deg
);
  logic              win_open;
  logic [MULT_W-1:0] nxt_mult, nxt_ceil;

  function automatic logic [MULT_W-1:0] clamp_req(input logic [MULT_W-1:0] r,
                                                  input logic [MULT_W-1:0] c);
    if (r < MULT_W'(MIN_MULT)) return MULT_W'(MIN_MULT);
    if (r > c) return c;
    return r;
  endfunction

  function automatic logic [MULT_W-1:0] dec_floor(input logic [MULT_W-1:0] m);
    return (m > MULT_W'(MIN_MULT)) ? m - 1'b1 : MULT_W'(MIN_MULT);
  endfunction

  assign win_now = win_open | sec_tick;

  always_comb begin
    nxt_mult = mult;
    nxt_ceil = ceil_m;
    case (act)
      ACT_CUT: begin
        nxt_mult = dec_floor(mult);
        nxt_ceil = dec_floor(mult);
      end
      ACT_RESTORE: nxt_ceil = MULT_W'(ABS_MULT);
      ACT_STEP:    nxt_ceil = ceil_m + 1'b1;
      ACT_SET:     nxt_mult = clamp_req(set_mult, ceil_m);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mult     <= MULT_W'(DEF_MULT);
      ceil_m   <= MULT_W'(ABS_MULT);
      mult_chg <= 1'b0;
      win_open <= 1'b1;
      temp_q   <= '0;
      temp_deg <= '0;
    end else begin
      mult     <= nxt_mult;
      ceil_m   <= nxt_ceil;
      mult_chg <= (nxt_mult != mult);
      win_open <= (act == ACT_CUT) ? 1'b0 : win_now;
      if (samp_valid) begin
        temp_q   <= invalid ? '0 : q_in;
        temp_deg <= invalid ? '0 : deg_in;
      end
    end
  end
endmodule

// File: rtl/thermal_throttle_gov.sv
module thermal_throttle_gov
  import thr_pkg::*;
#(
  parameter int MULT_W   = 8,
  parameter int HYST_W   = 8,
  parameter int DEF_MULT = 100,
  parameter int ABS_MULT = 125,
  parameter int MIN_MULT = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sec_tick,
  input  logic                    samp_valid,
  input  logic [CODE_W-1:0]       samp_code,
  input  logic signed [DEG_W-1:0] target_deg,
  input  logic [HYST_W-1:0]       hyst_deg,
  input  logic                    set_valid,
  input  logic [MULT_W-1:0]       set_mult,
  output logic [MULT_W-1:0]       mult,
  output logic [MULT_W-1:0]       ceil_mult,
  output logic                    mult_chg,
  output logic signed [Q_W-1:0]   temp_q,
  output logic signed [DEG_W-1:0] temp_deg
);
  logic                    invalid_w;
  logic signed [Q_W-1:0]   q_w;
  logic signed [DEG_W-1:0] deg_w;
  logic                    win_w;
  act_e                    act_w;

  thr_conv u_conv (
    .code    (samp_code),
    .invalid (invalid_w),
    .q       (q_w),
    .deg     (deg_w)
  );

  thr_decide #(.MULT_W(MULT_W), .HYST_W(HYST_W), .ABS_MULT(ABS_MULT)) u_decide (
    .samp_valid (samp_valid),
    .invalid    (invalid_w),
    .deg        (deg_w),
    .target     (target_deg),
    .hyst       (hyst_deg),
    .win_open   (win_w),
    .set_valid  (set_valid),
    .mult       (mult),
    .ceil_m     (ceil_mult),
    .act        (act_w)
  );

  thr_state #(.MULT_W(MULT_W), .DEF_MULT(DEF_MULT), .ABS_MULT(ABS_MULT),
              .MIN_MULT(MIN_MULT)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .act        (act_w),
    .set_mult   (set_mult),
    .samp_valid (samp_valid),
    .invalid    (invalid_w),
    .q_in       (q_w),
    .deg_in     (deg_w),
    .win_now    (win_w),
    .mult       (mult),
    .ceil_m     (ceil_mult),
    .mult_chg   (mult_chg),
    .temp_q     (temp_q),
    .temp_deg   (temp_deg)
  );
endmodule

// File: rtl/thr_gov_chk.sv
module thr_gov_chk
  import thr_pkg::*;
#(
  parameter int MULT_W   = 8,
  parameter int ABS_MULT = 125,
  parameter int MIN_MULT = 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sec_tick,
  input logic                  samp_valid,
  input logic [CODE_W-1:0]     samp_code,
  input act_e                  act,
  input logic [MULT_W-1:0]     mult,
  input logic [MULT_W-1:0]     ceil_mult,
  input logic                  mult_chg,
  input logic signed [Q_W-1:0] temp_q
);
  logic cut_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) cut_seen <= 1'b0;
    else if (act == ACT_CUT) cut_seen <= 1'b1;
    else if (sec_tick) cut_seen <= 1'b0;
  end

  // R9
  chg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mult_chg == (mult != $past(mult))));

  // R3
  mult_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mult >= MULT_W'(MIN_MULT)) && (mult <= ceil_mult));

  // R5
  ceil_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ceil_mult <= MULT_W'(ABS_MULT));

  // R3
  cut_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_CUT) |=> (ceil_mult == mult) &&
      ((mult == $past(mult) - 1'b1) || (mult == MULT_W'(MIN_MULT))));

  // R4
  one_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_CUT) |-> (!cut_seen || sec_tick));

  // R2
  invalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && ((samp_code == '0) || (samp_code == '1))) |=>
      (temp_q == '0) && $stable(ceil_mult) && $stable(mult));

  // R6
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_STEP) |=> (ceil_mult == $past(ceil_mult) + 1'b1));
endmodule

bind thermal_throttle_gov thr_gov_chk #(.MULT_W(MULT_W), .ABS_MULT(ABS_MULT),
                                        .MIN_MULT(MIN_MULT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sec_tick   (sec_tick),
  .samp_valid (samp_valid),
  .samp_code  (samp_code),
  .act        (act_w),
  .mult       (mult),
  .ceil_mult  (ceil_mult),
  .mult_chg   (mult_chg),
  .temp_q     (temp_q)
);

// File: tb/thermal_throttle_gov_tb.sv
module thermal_throttle_gov_tb;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0, samp_valid = 1'b0, set_valid = 1'b0;
  logic [15:0] samp_code = '0;
  logic signed [9:0] target_deg = '0;
  logic [7:0] hyst_deg = '0, set_mult = '0;
  logic [7:0] mult, ceil_mult;
  logic mult_chg;
  logic signed [13:0] temp_q;
  logic signed [9:0] temp_deg;

  int vectors = 0, errors = 0;
  int m_mult, m_ceil, m_tq, m_td, m_chg;
  bit m_used;
  logic [31:0] seed = 32'h1234_5678;

  always #(PERIOD/2) clk = ~clk;

  thermal_throttle_gov u_dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .samp_valid(samp_valid),
    .samp_code(samp_code), .target_deg(target_deg), .hyst_deg(hyst_deg),
    .set_valid(set_valid), .set_mult(set_mult), .mult(mult),
    .ceil_mult(ceil_mult), .mult_chg(mult_chg), .temp_q(temp_q),
    .temp_deg(temp_deg)
  );

  function automatic int code_val(input logic [15:0] c);
    int s, r;
    s = int'(c);
    if (s >= 32768) s = s - 65536;
    r = ((s % 4) + 4) % 4;
    return (s - r) / 4;
  endfunction

  function automatic int round_deg(input int v);
    if (v >= 0) return (2 * v + 32) / 64;
    return -((-2 * v + 32) / 64);
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return {16'd0, seed[30:15]};
  endfunction

  task automatic cmp(input int got, input int exp, input string what, input string tag);
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  task automatic model_step();
    int old_m, v, d, tg, h;
    old_m = m_mult;
    tg = int'(target_deg);
    h = int'(hyst_deg);
    if (sec_tick) m_used = 1'b0;
    if (samp_valid) begin
      if (samp_code == 16'h0000 || samp_code == 16'hFFFF) begin
        m_tq = 0; m_td = 0;
      end else begin
        v = code_val(samp_code);
        d = round_deg(v);
        m_tq = v; m_td = d;
        if (d > tg + h) begin
          if (!m_used) begin
            m_mult = (m_mult > 1) ? m_mult - 1 : 1;
            m_ceil = m_mult;
            m_used = 1'b1;
          end
        end else if (m_ceil < 125 && d < tg) begin
          if (d < tg - h) m_ceil = 125;
          else if (m_mult == m_ceil) m_ceil = m_ceil + 1;
        end
      end
    end else if (set_valid) begin
      m_mult = int'(set_mult);
      if (m_mult < 1) m_mult = 1;
      if (m_mult > m_ceil) m_mult = m_ceil;
    end
    m_chg = (m_mult != old_m) ? 1 : 0;
  endtask

  // drive at a negedge, model, then compare at the following negedge
  task automatic vec(input bit tk, input bit sv, input logic [15:0] code,
                     input bit rv, input logic [7:0] rm, input string tag);
    sec_tick = tk; samp_valid = sv; samp_code = code;
    set_valid = rv; set_mult = rm;
    model_step();
    @(negedge clk);
    vectors++;
    cmp(int'(mult), m_mult, "mult", {tag, " R3 R8"});
    cmp(int'(ceil_mult), m_ceil, "ceil", {tag, " R5 R6"});
    cmp(int'(mult_chg), m_chg, "mult_chg", {tag, " R9"});
    cmp(int'(temp_q), m_tq, "temp_q", {tag, " R1 R2"});
    cmp(int'(temp_deg), m_td, "temp_deg", {tag, " R1"});
    sec_tick = 0; samp_valid = 0; set_valid = 0;
  endtask

  function automatic logic [15:0] deg_code(input int dg, input int frac);
    return 16'((dg * 32 + frac) * 4);
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_mult = 100; m_ceil = 125; m_tq = 0; m_td = 0; m_chg = 0; m_used = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    vectors++;
    cmp(int'(mult), 100, "mult", "R10");
    cmp(int'(ceil_mult), 125, "ceil", "R10");
    cmp(int'(mult_chg), 0, "mult_chg", "R10");
    cmp(int'(temp_q), 0, "temp_q", "R10");
    cmp(int'(temp_deg), 0, "temp_deg", "R10");

    // R1 conversion sweep, target far above any reading so no action
    target_deg = 10'sd300; hyst_deg = 8'd0;
    for (int c = 0; c < 65536; c += 37) vec(0, 1, 16'(c), 0, 8'd0, "R1");
    for (int f = -20; f <= 20; f++) begin
      vec(0, 1, 16'(f * 4 + 64), 0, 8'd0, "R1");
      vec(0, 1, 16'(f * 4 - 64), 0, 8'd0, "R1");
    end
    vec(0, 1, 16'h8000, 0, 8'd0, "R1");
    vec(0, 1, 16'h7FFF, 0, 8'd0, "R1");
    vec(0, 1, 16'hFFFF, 0, 8'd0, "R2");
    vec(0, 0, 16'h1234, 0, 8'd0, "R1");
    vec(0, 1, 16'h0000, 0, 8'd0, "R2");

    // R4 window: several hot samples, one cut, then tick reopens
    target_deg = 10'sd60; hyst_deg = 8'd5;
    vec(0, 1, deg_code(70, 0), 0, 8'd0, "R4");
    vec(0, 1, deg_code(70, 0), 0, 8'd0, "R4");
    vec(0, 1, deg_code(80, 0), 0, 8'd0, "R4");
    vec(1, 0, 16'd0, 0, 8'd0, "R4");
    vec(0, 1, deg_code(70, 0), 0, 8'd0, "R4");
    vec(1, 1, deg_code(70, 0), 0, 8'd0, "R4");
    vec(0, 1, deg_code(66, -17), 0, 8'd0, "R4");
    // R7 neutral band, window reopened but no heat
    vec(1, 1, deg_code(65, 15), 0, 8'd0, "R7");
    vec(0, 1, deg_code(60, 0), 0, 8'd0, "R7");
    vec(0, 1, deg_code(59, 16), 0, 8'd0, "R7");
    // R6 step while mult equals ceiling, R5 restore
    vec(0, 1, deg_code(57, 0), 0, 8'd0, "R6");
    vec(0, 1, deg_code(55, 0), 0, 8'd0, "R6");
    vec(0, 1, deg_code(55, -17), 0, 8'd0, "R5");
    // R8 clamping and ignored request under a sample
    vec(0, 0, 16'd0, 1, 8'd200, "R8");
    vec(0, 0, 16'd0, 1, 8'd0, "R8");
    vec(0, 1, deg_code(62, 0), 1, 8'd90, "R8");
    vec(0, 0, 16'd0, 1, 8'd1, "R8");
    vec(1, 1, deg_code(90, 0), 0, 8'd0, "R3");
    vec(1, 1, deg_code(90, 0), 0, 8'd0, "R3");
    vec(0, 1, deg_code(50, 0), 0, 8'd0, "R5");

    // mixed sequences in two configurations
    for (int pass = 0; pass < 2; pass++) begin
      target_deg = pass ? -10'sd5 : 10'sd60;
      hyst_deg = pass ? 8'd0 : 8'd5;
      for (int i = 0; i < 1500; i++) begin
        logic [31:0] a, b;
        int dg;
        logic [15:0] cd;
        a = rnd(); b = rnd();
        dg = int'(target_deg) + int'(a[3:0]) - 8;
        cd = deg_code(dg, int'(b[5:0]) - 32);
        if (a[7:4] == 0) cd = b[6] ? 16'hFFFF : 16'h0000;
        vec(a[9:8] == 0, a[11:10] != 0, cd, a[14:12] == 0, 8'(b[13:6] % 140), "R3 R4");
      end
    end
    finish_run();
  end
endmodule